// File: doc/BRIEF.md
# Transactional Access Signature Conflict Logger

This per-core unit keeps compact hashed signatures of the lines that the running transaction has speculatively read and written. It also keeps a second read/write signature pair that software fills with the combined speculative footprint of the threads it has descheduled. Each local transactional access adds its line address to the read or the write signature. Each incoming coherence request (a snoop) is compared against the signatures. A snoop can report a conflict that did not happen, because signatures alias. It never misses a line that was actually inserted.

A detected conflict is only recorded. The unit keeps three conflict tables, one per conflict kind, with one bit per remote requester identifier. A snoop that hits sets the bit of its requester in the matching table. The tables therefore name the transactions that conflicted and hold no addresses. Resolution stays with software, which reads the tables whenever it likes and clears what it has handled. Through a small register port software can also read and write every signature word, to save and restore the signatures on a context switch, and it can wipe either signature pair with one command.

Top module: `sig_conflict_unit`

## Requirements
- R1: After reset all four signatures and all three tables are zero, and `snpConflict`, `conflictPending` and `swRdata` are low.
- R2: A local access inserts its line address into the running read signature (locWrite=0) or the running write signature (locWrite=1). Two bits are set, at indices hA and hB of the 256-bit vector. With a 32-bit address a and an 8-bit index: hA bit (i mod 8) is the XOR of every a[i]; hB bit ((7 - i mod 8) + i div 8) mod 8 is the XOR of every a[i]. Local accesses never change the summary signatures.
- R3: A signature matches a snoop address when both of that address's index bits are set in it. A remote write is compared with both the read and the write signatures. A remote read is compared only with the write signatures. The running pair and the summary pair take part alike.
- R4: A remote write that matches a read signature sets bit `snpId` of table RW (sw address 32). A remote read that matches a write signature sets that bit of table WR (address 33). A remote write that matches a write signature sets that bit of table WW (address 34). `snpConflict` is high for exactly the one cycle after any snoop that set a bit.
- R5: Table bits are sticky. Further snoops, matching or not, never clear them.
- R6: A snoop in the same cycle as a local access to the same line sees that access.
- R7: Summary signatures are written only through the register port. Matches in them log conflicts exactly as matches in the running signatures do.
- R8: Register port: addresses 0-31 are signature words. Address bits [4:3] pick the signature: 0 running read, 1 running write, 2 summary read, 3 summary write. Bits [2:0] pick the word, and word w is signature bits [32w+31:32w]. A write replaces the word.
- R9: A write to address 35 with data bit 0 set clears both running signatures in one cycle. Data bit 1 clears both summary signatures. A local access in that same cycle is still inserted after the clear.
- R10: Writing to a table address clears the bits whose data bit is 1 and leaves the others. A conflict logged in the same cycle as the clear wins.
- R11: A read (swValid=1, swWrite=0) loads `swRdata` at the next edge with the state before that edge. Tables read zero-extended, and addresses 35-63 read zero. `swRdata` holds its value when no read is made.
- R12: `conflictPending` is high whenever any bit of any table is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locValid | input | 1 | Local transactional access this cycle |
| locWrite | input | 1 | Local access is a write |
| locAddr | input | 32 | Local line address |
| snpValid | input | 1 | Snoop this cycle |
| snpWrite | input | 1 | Snoop is a remote write |
| snpAddr | input | 32 | Snoop line address |
| snpId | input | 4 | Remote transaction identifier |
| swValid | input | 1 | Register port request |
| swWrite | input | 1 | Register port write |
| swAddr | input | 6 | Register address |
| swWdata | input | 32 | Register write data |
| swRdata | output | 32 | Register read data, one cycle after the request |
| snpConflict | output | 1 | Pulse: previous snoop logged a conflict |
| conflictPending | output | 1 | Some table bit is set |

## Verification
The hardest cases to reach are coincidences in a single cycle. One is a snoop that arrives together with the local access it must see. Another is a table clear that lands in the same edge as a new conflict on the same bit. A third is a wipe command issued while an insertion is in flight. The bench drives each of them through one scenario task that sets every port for the same cycle. A bench-side model of the four signatures and three tables, built from the hash rule and the matching rules, predicts the outcome. Summary-signature matches are reached by loading summary words through the register port, because local accesses cannot reach them.

// File: rtl/scd_pkg.sv
package scd_pkg;

  typedef enum logic [1:0] {
    SIG_RUN_RD = 2'd0,
    SIG_RUN_WR = 2'd1,
    SIG_SUM_RD = 2'd2,
    SIG_SUM_WR = 2'd3
  } sigKind_e;

  localparam int NUM_SIGS = 4;
  localparam int NUM_TBLS = 3;
  localparam logic [1:0] TBL_CMD = 2'd3;

  typedef struct packed {
    logic insRd;
    logic insWr;
    logic snpRd;
    logic snpWr;
    logic sigWrEn;
    logic tblClrEn;
    logic clrRun;
    logic clrSum;
    logic rdEn;
    logic rdTbl;
    logic rdTblOk;
    logic [1:0] sigSel;
    logic [1:0] tblSel;
  } scdStrobes_t;

endpackage

// File: rtl/scd_ctrl.sv
module scd_ctrl
  import scd_pkg::*;
#(
  parameter int WSEL_W = 3,
  parameter int SW_AW  = WSEL_W + 3
) (
  input  logic              locValid,
  input  logic              locWrite,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic              swValid,
  input  logic              swWrite,
  input  logic [SW_AW-1:0]  swAddr,
  input  logic              cmdRunBit,
  input  logic              cmdSumBit,
  output scdStrobes_t       stb,
  output logic [WSEL_W-1:0] wordSel
);

  logic tblRegion;
  logic tblOk;
  logic swWr;
  logic isCmd;

  assign tblRegion = swAddr[SW_AW-1];
  assign tblOk     = tblRegion && (swAddr[SW_AW-2:2] == '0);
  assign swWr      = swValid && swWrite;
  assign isCmd     = tblOk && (swAddr[1:0] == TBL_CMD);
  assign wordSel   = swAddr[WSEL_W-1:0];

  always_comb begin
    stb          = '0;
    stb.insRd    = locValid && !locWrite;
    stb.insWr    = locValid && locWrite;
    stb.snpRd    = snpValid && !snpWrite;
    stb.snpWr    = snpValid && snpWrite;
    stb.sigSel   = swAddr[SW_AW-2 -: 2];
    stb.tblSel   = swAddr[1:0];
    stb.sigWrEn  = swWr && !tblRegion;
    stb.tblClrEn = swWr && tblOk && !isCmd;
    stb.clrRun   = swWr && isCmd && cmdRunBit;
    stb.clrSum   = swWr && isCmd && cmdSumBit;
    stb.rdEn     = swValid && !swWrite;
    stb.rdTbl    = tblRegion;
    stb.rdTblOk  = tblOk && !isCmd;
  end

endmodule

// File: rtl/scd_datapath.sv
module scd_datapath
  import scd_pkg::*;
#(
  parameter int SIG_BITS = 256,
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int NUM_TX   = 16,
  parameter int IDX_W    = $clog2(SIG_BITS),
  parameter int WORDS    = SIG_BITS / WORD_W,
  parameter int WSEL_W   = $clog2(WORDS),
  parameter int ID_W     = $clog2(NUM_TX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  scdStrobes_t       stb,
  input  logic [WSEL_W-1:0] wordSel,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpId,
  input  logic [WORD_W-1:0] swWdata,
  output logic [WORD_W-1:0] swRdata,
  output logic              snpConflict,
  output logic              conflictPending
);

  function automatic logic [IDX_W-1:0] hashA(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++) h[IDX_W'(i % IDX_W)] ^= a[i];
    return h;
  endfunction

  function automatic logic [IDX_W-1:0] hashB(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++)
      h[IDX_W'(((IDX_W - 1 - (i % IDX_W)) + (i / IDX_W)) % IDX_W)] ^= a[i];
    return h;
  endfunction

  logic [SIG_BITS-1:0] insVec;
  logic [SIG_BITS-1:0] probeVec;

  always_comb begin
    insVec = '0;
    insVec[hashA(locAddr)] = 1'b1;
    insVec[hashB(locAddr)] = 1'b1;
    probeVec = '0;
    probeVec[hashA(snpAddr)] = 1'b1;
    probeVec[hashB(snpAddr)] = 1'b1;
  end

  logic [NUM_SIGS-1:0][SIG_BITS-1:0] sigCur;
  logic [NUM_SIGS-1:0][SIG_BITS-1:0] sigEff;
  logic [NUM_SIGS-1:0]               sigHit;

  for (genvar k = 0; k < NUM_SIGS; k++) begin : gSig
    localparam bit IS_RUN = (k < 2);
    logic [SIG_BITS-1:0] sigQ;
    logic [SIG_BITS-1:0] sigD;
    logic                insHere;

    if (k == int'(SIG_RUN_RD)) begin : gInsRd
      assign insHere = stb.insRd;
    end else if (k == int'(SIG_RUN_WR)) begin : gInsWr
      assign insHere = stb.insWr;
    end else begin : gNoIns
      assign insHere = 1'b0;
    end

    always_comb begin
      sigD = sigQ;
      if ((IS_RUN && stb.clrRun) || (!IS_RUN && stb.clrSum)) sigD = '0;
      if (stb.sigWrEn && (stb.sigSel == 2'(k))) begin
        for (int w = 0; w < WORDS; w++)
          if (wordSel == WSEL_W'(w)) sigD[w*WORD_W +: WORD_W] = swWdata;
      end
      if (insHere) sigD = sigD | insVec;
    end

    always_ff @(posedge clk) begin
      if (!rstN) sigQ <= '0;
      else       sigQ <= sigD;
    end

    assign sigCur[k] = sigQ;
    assign sigEff[k] = insHere ? (sigQ | insVec) : sigQ;
    assign sigHit[k] = ((sigEff[k] & probeVec) == probeVec);
  end

  logic rdMatch;
  logic wrMatch;
  assign rdMatch = sigHit[SIG_RUN_RD] || sigHit[SIG_SUM_RD];
  assign wrMatch = sigHit[SIG_RUN_WR] || sigHit[SIG_SUM_WR];

  logic [NUM_TX-1:0] idMask;
  always_comb begin
    idMask = '0;
    idMask[snpId] = 1'b1;
  end

  logic [NUM_TBLS-1:0] tblSet;
  assign tblSet[0] = stb.snpWr && rdMatch;
  assign tblSet[1] = stb.snpRd && wrMatch;
  assign tblSet[2] = stb.snpWr && wrMatch;

  logic [NUM_TBLS-1:0][NUM_TX-1:0] tblQ;
  for (genvar t = 0; t < NUM_TBLS; t++) begin : gTbl
    logic [NUM_TX-1:0] clrMask;
    logic [NUM_TX-1:0] setMask;
    assign clrMask = (stb.tblClrEn && (stb.tblSel == 2'(t))) ? swWdata[NUM_TX-1:0] : '0;
    assign setMask = tblSet[t] ? idMask : '0;
    always_ff @(posedge clk) begin
      if (!rstN) tblQ[t] <= '0;
      else       tblQ[t] <= (tblQ[t] & ~clrMask) | setMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) snpConflict <= 1'b0;
    else       snpConflict <= |tblSet;
  end

  assign conflictPending = |tblQ;

  logic [WORD_W-1:0] rdWord;
  always_comb begin
    rdWord = '0;
    if (!stb.rdTbl) begin
      for (int w = 0; w < WORDS; w++)
        if (wordSel == WSEL_W'(w)) rdWord = sigCur[stb.sigSel][w*WORD_W +: WORD_W];
    end else if (stb.rdTblOk) begin
      for (int t = 0; t < NUM_TBLS; t++)
        if (stb.tblSel == 2'(t)) rdWord = WORD_W'(tblQ[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          swRdata <= '0;
    else if (stb.rdEn)  swRdata <= rdWord;
  end

endmodule

// File: rtl/sig_conflict_unit.sv
module sig_conflict_unit
  import scd_pkg::*;
#(
  parameter int SIG_BITS = 256,
  parameter int ADDR_W   = 32,
  parameter int WORD_W   = 32,
  parameter int NUM_TX   = 16,
  localparam int WORDS   = SIG_BITS / WORD_W,
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int SW_AW   = WSEL_W + 3,
  localparam int ID_W    = $clog2(NUM_TX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locValid,
  input  logic              locWrite,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpId,
  input  logic              swValid,
  input  logic              swWrite,
  input  logic [SW_AW-1:0]  swAddr,
  input  logic [WORD_W-1:0] swWdata,
  output logic [WORD_W-1:0] swRdata,
  output logic              snpConflict,
  output logic              conflictPending
);

  scdStrobes_t       stb;
  logic [WSEL_W-1:0] wordSel;

  scd_ctrl #(.WSEL_W(WSEL_W), .SW_AW(SW_AW)) ctrl_i (
    .locValid (locValid),
    .locWrite (locWrite),
    .snpValid (snpValid),
    .snpWrite (snpWrite),
    .swValid  (swValid),
    .swWrite  (swWrite),
    .swAddr   (swAddr),
    .cmdRunBit(swWdata[0]),
    .cmdSumBit(swWdata[1]),
    .stb      (stb),
    .wordSel  (wordSel)
  );

  scd_datapath #(
    .SIG_BITS(SIG_BITS), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_TX(NUM_TX)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .wordSel        (wordSel),
    .locAddr        (locAddr),
    .snpAddr        (snpAddr),
    .snpId          (snpId),
    .swWdata        (swWdata),
    .swRdata        (swRdata),
    .snpConflict    (snpConflict),
    .conflictPending(conflictPending)
  );

endmodule

// File: rtl/sig_conflict_unit_chk.sv
module sig_conflict_unit_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              snpValid,
  input logic              swValid,
  input logic              swWrite,
  input logic [WORD_W-1:0] swRdata,
  input logic              snpConflict,
  input logic              conflictPending
);

  assert_pulse_follows_snoop_R4: assert property (@(posedge clk) disable iff (!rstN)
    snpConflict |-> $past(snpValid));

  assert_pulse_is_logged_R4: assert property (@(posedge clk) disable iff (!rstN)
    snpConflict |-> conflictPending);

  assert_pending_rise_needs_snoop_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(conflictPending) |-> $past(snpValid));

  assert_sticky_until_sw_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(conflictPending) |-> $past(swValid && swWrite));

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(swValid && !swWrite) |-> $stable(swRdata));

endmodule

bind sig_conflict_unit sig_conflict_unit_chk #(.WORD_W(WORD_W)) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .snpValid       (snpValid),
  .swValid        (swValid),
  .swWrite        (swWrite),
  .swRdata        (swRdata),
  .snpConflict    (snpConflict),
  .conflictPending(conflictPending)
);

// File: tb/sig_conflict_unit_tb.sv
module sig_conflict_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic locValid = 0, locWrite = 0;
  logic [31:0] locAddr = '0;
  logic snpValid = 0, snpWrite = 0;
  logic [31:0] snpAddr = '0;
  logic [3:0] snpId = '0;
  logic swValid = 0, swWrite = 0;
  logic [5:0] swAddr = '0;
  logic [31:0] swWdata = '0;
  logic [31:0] swRdata;
  logic snpConflict, conflictPending;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_conflict_unit dut_i (.*);

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  logic [255:0] mSig [4];
  logic [15:0]  mTbl [3];

  function automatic logic [7:0] hA(logic [31:0] a);
    logic [7:0] h = '0;
    for (int i = 0; i < 32; i++) h[i % 8] ^= a[i];
    return h;
  endfunction

  function automatic logic [7:0] hB(logic [31:0] a);
    logic [7:0] h = '0;
    for (int i = 0; i < 32; i++) h[((7 - (i % 8)) + (i / 8)) % 8] ^= a[i];
    return h;
  endfunction

  function automatic logic [255:0] bitsOf(logic [31:0] a);
    logic [255:0] v = '0;
    v[hA(a)] = 1'b1;
    v[hB(a)] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle with every input driven together; the model predicts from the requirements.
  task automatic step(input string tag,
                      input bit lV, input bit lW, input logic [31:0] lA,
                      input bit sV, input bit sW, input logic [31:0] sA, input logic [3:0] sId,
                      input bit wV, input bit wW, input logic [5:0] wA, input logic [31:0] wD);
    logic [255:0] eff [4];
    logic [255:0] pv, iv;
    logic [2:0] setT;
    logic [31:0] expRd;
    bit rdM, wrM;
    locValid = lV; locWrite = lW; locAddr = lA;
    snpValid = sV; snpWrite = sW; snpAddr = sA; snpId = sId;
    swValid = wV; swWrite = wW; swAddr = wA; swWdata = wD;
    iv = bitsOf(lA);
    pv = bitsOf(sA);
    for (int k = 0; k < 4; k++) eff[k] = mSig[k];
    if (lV) eff[lW ? 1 : 0] |= iv;                       // R6 bypass
    rdM = ((eff[0] & pv) == pv) || ((eff[2] & pv) == pv);
    wrM = ((eff[1] & pv) == pv) || ((eff[3] & pv) == pv);
    setT[0] = sV && sW && rdM;
    setT[1] = sV && !sW && wrM;
    setT[2] = sV && sW && wrM;
    expRd = '0;
    if (!wA[5]) expRd = mSig[wA[4:3]][wA[2:0]*32 +: 32];
    else if (wA[4:2] == 0 && wA[1:0] != 3) expRd = {16'h0, mTbl[wA[1:0]]};
    @(posedge clk);
    for (int t = 0; t < 3; t++) begin
      if (wV && wW && wA[5] && wA[4:2] == 0 && wA[1:0] == t) mTbl[t] &= ~wD[15:0];
      if (setT[t]) mTbl[t][sId] = 1'b1;
    end
    if (wV && wW && wA == 6'd35) begin
      if (wD[0]) begin mSig[0] = '0; mSig[1] = '0; end
      if (wD[1]) begin mSig[2] = '0; mSig[3] = '0; end
    end
    if (wV && wW && !wA[5]) mSig[wA[4:3]][wA[2:0]*32 +: 32] = wD;
    if (lV) mSig[lW ? 1 : 0] |= iv;
    @(negedge clk);
    chk(snpConflict == |setT, {tag, " R4 snpConflict"}, 32'(snpConflict), 32'(|setT));
    chk(conflictPending == |{mTbl[0], mTbl[1], mTbl[2]}, {tag, " R12 pending"},
        32'(conflictPending), 32'(|{mTbl[0], mTbl[1], mTbl[2]}));
    if (wV && !wW) chk(swRdata == expRd, {tag, " R11 rdata"}, swRdata, expRd);
    locValid = 0; snpValid = 0; swValid = 0; swWrite = 0;
  endtask

  task automatic loc(input string tag, input bit w, input logic [31:0] a);
    step(tag, 1, w, a, 0, 0, '0, '0, 0, 0, '0, '0);
  endtask
  task automatic snoop(input string tag, input bit w, input logic [31:0] a, input logic [3:0] id);
    step(tag, 0, 0, '0, 1, w, a, id, 0, 0, '0, '0);
  endtask
  task automatic swW(input string tag, input logic [5:0] a, input logic [31:0] d);
    step(tag, 0, 0, '0, 0, 0, '0, '0, 1, 1, a, d);
  endtask
  task automatic swR(input string tag, input logic [5:0] a);
    step(tag, 0, 0, '0, 0, 0, '0, '0, 1, 0, a, '0);
  endtask
  task automatic readSig(input string tag, input int sel);
    for (int w = 0; w < 8; w++) swR(tag, 6'(sel * 8 + w));
  endtask
  task automatic readTbls(input string tag);
    for (int t = 0; t < 3; t++) swR(tag, 6'(32 + t));
  endtask

  task automatic tReset();
    chk(swRdata == 0 && !snpConflict && !conflictPending, "R1 outputs after reset",
        {29'h0, 1'b0, snpConflict, conflictPending}, 32'h0);
    readTbls("R1 tables");
    readSig("R1 run write sig", 1);
    readSig("R1 sum read sig", 2);
    swR("R11 unused address", 6'd50);
  endtask

  task automatic tInsert();
    loc("R2 read insert", 0, 32'h0000_1240);
    loc("R2 write insert", 1, 32'hA5C3_0F80);
    readSig("R2 R8 run read sig", 0);
    readSig("R2 R8 run write sig", 1);
    readSig("R2 summary untouched", 3);
  endtask

  task automatic tRemote();
    snoop("R3 remote read of read-only line", 0, 32'h0000_1240, 4'd2);
    snoop("R3 R4 remote write hits read sig", 1, 32'h0000_1240, 4'd3);
    snoop("R3 R4 remote read hits write sig", 0, 32'hA5C3_0F80, 4'd5);
    snoop("R3 R4 remote write hits write sig", 1, 32'hA5C3_0F80, 4'd7);
    snoop("R3 unrelated line", 1, 32'h7777_0000, 4'd9);
    readTbls("R4 tables");
  endtask

  task automatic tSticky();
    snoop("R5 miss snoop", 0, 32'h1111_2222, 4'd3);
    snoop("R5 read snoop", 0, 32'h0000_1240, 4'd7);
    readTbls("R5 tables kept");
  endtask

  task automatic tClearTbl();
    swW("R10 W1C table RW", 6'd32, 32'h0000_0008);
    readTbls("R10 after clear");
    // clear of bit 5 in WR with a new WR conflict from id 5 in the same cycle
    step("R10 set beats clear", 0, 0, '0, 1, 0, 32'hA5C3_0F80, 4'd5, 1, 1, 6'd33, 32'h0000_FFFF);
    readTbls("R10 after race");
  endtask

  task automatic tSameCycle();
    step("R6 snoop sees same-cycle insert", 1, 0, 32'h0BAD_F00D, 1, 1, 32'h0BAD_F00D, 4'd11,
         0, 0, '0, '0);
    readTbls("R6 tables");
  endtask

  task automatic tWipe();
    // wipe running sigs while a write insert lands in the same cycle
    step("R9 wipe with insert", 1, 1, 32'h0000_3300, 0, 0, '0, '0, 1, 1, 6'd35, 32'h1);
    readSig("R9 run read cleared", 0);
    readSig("R9 run write keeps new", 1);
    snoop("R9 old line no longer hits", 1, 32'h0000_1240, 4'd12);
  endtask

  task automatic tSummary();
    logic [255:0] v;
    v = bitsOf(32'hDEAD_0040);
    for (int w = 0; w < 8; w++) swW("R7 R8 load summary write", 6'(24 + w), v[w*32 +: 32]);
    snoop("R7 remote read hits summary", 0, 32'hDEAD_0040, 4'd14);
    loc("R7 local write", 1, 32'hDEAD_0040);
    readSig("R7 summary unchanged by local", 3);
    swW("R9 wipe summary", 6'd35, 32'h2);
    readSig("R9 summary cleared", 3);
    swW("R10 clear all tables WW", 6'd34, 32'hFFFF);
    swW("R10 clear all tables RW", 6'd32, 32'hFFFF);
    swW("R10 clear all tables WR", 6'd33, 32'hFFFF);
    readTbls("R12 tables empty");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) mSig[k] = '0;
    for (int t = 0; t < 3; t++) mTbl[t] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tInsert();
    tRemote();
    tSticky();
    tClearTbl();
    tSameCycle();
    tWipe();
    tSummary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule